// File: doc/BRIEF.md
# PLL Lock Watch With Stretched Unlock Flag

This block watches the two divider pulse trains of a phase-locked loop: the divided-down reference and the divided-down oscillator feedback. It runs on the crystal clock and measures, in clock cycles, how far apart the rising edges of the two trains fall. A pair of edges further apart than a fixed window counts as a phase error. A train that produces no edge for longer than one reference period also counts as a phase error.

Any error sets an unlock flag. The flag then stays set for a fixed hold time, which restarts with every further error, so that a single short slip stays visible to slow logic or to a pull-up sensing circuit. The flag comes out twice. One copy is a registered status bit. The other is a registered enable for an external open-drain pull-down: while locked the pin is released, and while unlocked it is pulled low. After reset the loop is assumed unlocked until one full hold time passes with no error.

With the defaults (a 10.24 MHz clock, a 2048-cycle reference period), the window is 64 cycles (6.25 µs) and the hold is 32 reference periods (65536 cycles, 6.4 ms). Both inputs are taken to be synchronous to the clock.

Top module: `pll_lock_watch`

## Requirements
- R1: A rising edge (input sampled 0 on one clock, then 1 on the next) on one train, followed by a rising edge on the other train no more than WIN_CYC cycles later, is not an error. Edges in the same cycle are not an error either. Both orders are covered.
- R2: If WIN_CYC+1 cycles pass after a leading edge without a partner edge, that is one phase error. A partner edge arriving in exactly that cycle is discarded. A partner edge arriving later opens a new window of its own.
- R3: For each train separately, a gap of up to REF_PERIOD_CYC cycles between its rising edges is not an error. A gap of REF_PERIOD_CYC+1 cycles or more raises an error, which repeats for every REF_PERIOD_CYC cycles without an edge.
- R4: An error pulse registered on clock edge E sets the flag on edge E+1. The flag is released HOLD_PERIODS*REF_PERIOD_CYC edges after the most recent such setting edge. A further error restarts the count.
- R5: Reset is synchronous and active high. During reset and right after it, the flag and the pull-down enable are both 1. If no error occurs, they fall HOLD_PERIODS*REF_PERIOD_CYC cycles after the last reset edge.
- R6: `pd_en` and `unlocked` are registered and always equal: 1 drives the pin low, and 0 releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_div | input | 1 | Reference divider pulse train |
| fb_div | input | 1 | Feedback divider pulse train |
| pd_en | output | 1 | Enable for the open-drain pull-down (1 = pull low) |
| unlocked | output | 1 | Registered unlock status |

## Verification
The bench builds the block with WIN_CYC=4, REF_PERIOD_CYC=20 and HOLD_PERIODS=2, which gives a 40-cycle hold. With these values the whole edge-separation range from 0 to WIN_CYC+2 can be swept in both orders, and the feedback gap can be stepped across the REF_PERIOD_CYC boundary. The exact length of the stretched flag becomes a short count. That count can be predicted arithmetically for a single error, for a late-window double error and for two errors one period apart.

// File: rtl/plw_pkg.sv
package plw_pkg;
  typedef enum logic [1:0] {
    PW_IDLE     = 2'd0,
    PW_LEAD_REF = 2'd1,
    PW_LEAD_FB  = 2'd2
  } pw_state_e;

  localparam int unsigned NSRC    = 2;
  localparam int unsigned SRC_REF = 0;
  localparam int unsigned SRC_FB  = 1;
endpackage

// File: rtl/plw_rise.sv
module plw_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/plw_miss.sv
module plw_miss #(
  parameter int unsigned GAP_CYC = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  output logic miss
);
  localparam int unsigned CW = (GAP_CYC > 2) ? $clog2(GAP_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(GAP_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          miss_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      miss_q <= 1'b0;
    end else if (rise) begin
      cnt_q  <= '0;
      miss_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      miss_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      miss_q <= 1'b0;
    end
  end

  assign miss = miss_q;

  AST_EDGE_CLEARS_MISS: assert property (@(posedge clk) disable iff (rst)
    rise |=> !miss_q); // R3
endmodule

// File: rtl/plw_phase.sv
module plw_phase
  import plw_pkg::*;
#(
  parameter int unsigned WIN_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_ref,
  input  logic rise_fb,
  output logic err
);
  localparam int unsigned CW = $clog2(WIN_CYC + 2);
  localparam logic [CW-1:0] LIMIT = CW'(WIN_CYC + 1);
  localparam logic [CW-1:0] WIN_V = CW'(WIN_CYC);

  pw_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          err_q;
  logic          partner;

  assign partner = (state_q == PW_LEAD_REF) ? rise_fb : rise_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PW_IDLE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        PW_IDLE: begin
          cnt_q <= CW'(1);
          if (rise_ref && !rise_fb)      state_q <= PW_LEAD_REF;
          else if (rise_fb && !rise_ref) state_q <= PW_LEAD_FB;
        end
        PW_LEAD_REF, PW_LEAD_FB: begin
          if (cnt_q == LIMIT) begin
            err_q   <= 1'b1;
            state_q <= PW_IDLE;
          end else if (partner) begin
            state_q <= PW_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= PW_IDLE;
      endcase
    end
  end

  assign err = err_q;

  AST_SAME_CYCLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q == PW_IDLE && rise_ref && rise_fb) |=> !err_q); // R1
  AST_PARTNER_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (state_q != PW_IDLE && partner && cnt_q <= WIN_V) |=> !err_q); // R1
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    err_q |=> !err_q); // R2
endmodule

// File: rtl/plw_hold.sv
module plw_hold #(
  parameter int unsigned HOLD_CYC = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic err,
  output logic unlocked,
  output logic pd_en
);
  localparam int unsigned CW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          unl_q, unl_d;
  logic          pd_q;

  always_comb begin
    cnt_d = cnt_q;
    unl_d = unl_q;
    if (err) begin
      cnt_d = '0;
      unl_d = 1'b1;
    end else if (unl_q) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        unl_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      unl_q <= 1'b1;
      pd_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      unl_q <= unl_d;
      pd_q  <= unl_d;
    end
  end

  assign unlocked = unl_q;
  assign pd_en    = pd_q;

  AST_ERR_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    err |=> unl_q); // R4
  AST_RELEASE_AFTER_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(unl_q) |-> !$past(err)); // R4
  AST_PIN_MATCHES_FLAG: assert property (@(posedge clk) disable iff (rst)
    pd_q == unl_q); // R6
  AST_RESET_UNLOCKED: assert property (@(posedge clk)
    $past(rst) |-> (unl_q && pd_q)); // R5
endmodule

// File: rtl/pll_lock_watch.sv
module pll_lock_watch
  import plw_pkg::*;
#(
  parameter int unsigned WIN_CYC        = 64,
  parameter int unsigned REF_PERIOD_CYC = 2048,
  parameter int unsigned HOLD_PERIODS   = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_div,
  input  logic fb_div,
  output logic pd_en,
  output logic unlocked
);
  localparam int unsigned HOLD_CYC = HOLD_PERIODS * REF_PERIOD_CYC;

  logic [NSRC-1:0] lvl;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] miss;
  logic            phase_err;
  logic            any_err;

  assign lvl[SRC_REF] = ref_div;
  assign lvl[SRC_FB]  = fb_div;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    plw_rise u_rise (
      .clk  (clk),
      .rst  (rst),
      .lvl  (lvl[g]),
      .rise (rise[g])
    );
    plw_miss #(.GAP_CYC(REF_PERIOD_CYC)) u_miss (
      .clk  (clk),
      .rst  (rst),
      .rise (rise[g]),
      .miss (miss[g])
    );
  end

  plw_phase #(.WIN_CYC(WIN_CYC)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .rise_ref (rise[SRC_REF]),
    .rise_fb  (rise[SRC_FB]),
    .err      (phase_err)
  );

  assign any_err = phase_err | (|miss);

  plw_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .err      (any_err),
    .unlocked (unlocked),
    .pd_en    (pd_en)
  );

  AST_MISS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (|miss) |=> unlocked); // R3
  AST_PHASE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    phase_err |=> unlocked); // R2
endmodule

// File: tb/pll_lock_watch_test.sv
`timescale 1ns/1ps
module pll_lock_watch_test;
  localparam int WIN  = 4;
  localparam int REFP = 20;
  localparam int HP   = 2;
  localparam int HOLD = HP * REFP;
  localparam int PER  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_div = 1'b0;
  logic fb_div = 1'b0;
  logic pd_en, unlocked;

  int total = 0, bad = 0, pin_bad = 0, cyc = 0;
  int run_len = 0, last_run = 0;
  bit any_hi = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pll_lock_watch #(.WIN_CYC(WIN), .REF_PERIOD_CYC(REFP), .HOLD_PERIODS(HP)) uut (
    .clk(clk), .rst(rst), .ref_div(ref_div), .fb_div(fb_div),
    .pd_en(pd_en), .unlocked(unlocked)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic f);
    @(negedge clk);
    if (pd_en !== unlocked) pin_bad++;
    if (unlocked === 1'b1) begin
      run_len++;
      any_hi = 1;
    end else begin
      if (run_len != 0) last_run = run_len;
      run_len = 0;
    end
    ref_div = r;
    fb_div  = f;
    cyc++;
  endtask

  task automatic period(input int p, input bit ref_lead, input int d);
    for (int c = 0; c < p; c++) begin
      logic lead_v, lag_v;
      lead_v = (c < 2);
      lag_v  = (c >= d) && (c < d + 2);
      if (ref_lead) step(lead_v, lag_v);
      else          step(lag_v, lead_v);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) period(PER, 1'b1, 0);
  endtask

  initial begin
    while (!done && cyc < 150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) step(1'b0, 1'b0);
    check(unlocked === 1'b1, "R5 reset status", int'(unlocked), 1);
    check(pd_en === 1'b1, "R5 reset pull-down", int'(pd_en), 1);
    run_len = 1;
    rst = 1'b0;
    settle(6);
    check(last_run == HOLD, "R5 initial hold length", last_run, HOLD);
    check(unlocked === 1'b0, "R5 released after hold", int'(unlocked), 0);

    // R1 / R2 / R4: sweep edge separation in both orders
    for (int o = 0; o < 2; o++) begin
      for (int d = 0; d <= WIN + 2; d++) begin
        int exp_run;
        settle(6);
        any_hi = 0;
        last_run = 0;
        period(PER, o[0], d);
        settle(6);
        if (d <= WIN)
          check(any_hi == 0, "R1 separation inside window", int'(any_hi), 0);
        else
          check(any_hi == 1, "R2 separation beyond window", int'(any_hi), 1);
        if (d > WIN) begin
          exp_run = (d == WIN + 1) ? HOLD : HOLD + d;
          check(last_run == exp_run, "R4 stretched length", last_run, exp_run);
        end
        check(unlocked === 1'b0, "R1 relocked after settle", int'(unlocked), 0);
      end
    end

    // R3: gap sweep across the reference period
    for (int p = REFP - 2; p <= REFP + 2; p++) begin
      settle(6);
      any_hi = 0;
      repeat (5) period(p, 1'b1, 0);
      check(any_hi == (p > REFP), "R3 missing edge gap", int'(any_hi), int'(p > REFP));
      settle(6);
      check(unlocked === 1'b0, "R3 relocked after gap test", int'(unlocked), 0);
    end

    // R4: second error restarts the hold
    settle(6);
    last_run = 0;
    period(PER, 1'b1, WIN + 1);
    period(PER, 1'b1, WIN + 1);
    settle(8);
    check(last_run == HOLD + PER, "R4 hold restart", last_run, HOLD + PER);

    check(pin_bad == 0, "R6 pull-down equals status", pin_bad, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule